// File: doc/BRIEF.md
# TDMA Slot Sequencer With Guard Time

This block is the timing engine of a central fabric controller that divides link time into rounds of fixed-length slots. Slot boundaries come only from the controller's own clock. Each slot runs in three steps:

1. The engine asks for a stop command to every controlled host.
2. It waits a guard interval.
3. It asks for a resume command to each host that has a traffic class scheduled in that slot. The resume command carries that class.

Hosts are visited one switch at a time. Both the starting switch and the starting host inside each switch advance by one every slot, so no host is always served first.

A pulse on `start` launches a round. The slot-0 stop step mutes every host before any host is re-enabled. The engine reads the per-slot, per-host class from an external schedule store. The store is combinational: data for the presented address is valid in the same cycle. Requests go out over a valid/ready handshake. A separate assembler turns them into control frames. A pulse marks the end of the last slot, so a fresh schedule bank can be swapped in between rounds. A second pulse flags a slot that ended before its resume step could finish.

Configuration must stay stable while `busy` is high. The valid ranges are:

- slot length of at least 2 cycles
- guard length of at least 1 cycle
- 1 to `MAX_SLOTS` slots
- 1 to `MAX_SW` switches
- 1 to `MAX_HPS` hosts per switch

Top module: `tdma_slot_sequencer`

## Requirements
- R1: While reset is held and after it is released, `req_valid`, `busy`, `round_done` and `overrun` are all 0.
- R2: Each round's first requests are stop commands (`req_cmd`=0) to every configured host. No resume command (`req_cmd`=1) is issued in a slot until all its stop commands have been accepted.
- R3: Slot k of a round starts exactly k*`cfg_slot_len` cycles after slot 0. Slot 0's first request is valid in the cycle after `start` is sampled.
- R4: The resume step starts after exactly `cfg_guard_len` request-free cycles following the cycle in which the last stop command of the slot is accepted. Each host in that step takes one cycle when `req_ready` is high.
- R5: A schedule entry whose top bit (bit `CLS_W`) is 0 yields one resume command whose `req_class` equals the entry's low `CLS_W` bits. An entry with the top bit set is idle: that host gets no resume command in that slot.
- R6: Host index is {switch, host-in-switch}, with the host-in-switch in the low log2(`MAX_HPS`) bits. All hosts of one switch are visited before the next switch.
- R7: In slot k, visiting starts at switch k mod `cfg_num_sw` and at host k mod `cfg_hosts_per_sw`, and both wrap upward. The count restarts at 0 on every `start`.
- R8: A request that is not accepted keeps `req_valid`, `req_host` and `req_cmd` unchanged until it is accepted. The one exception is a slot end, which raises `overrun`.
- R9: If a slot ends before its resume step has finished, `overrun` pulses for one cycle. The next slot still begins on time.
- R10: After the last slot ends, `round_done` pulses for one cycle, `busy` falls in that same cycle, and the engine issues no further requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch a round (sampled when idle) |
| cfg_slot_len | input | LEN_W | Slot length in cycles |
| cfg_guard_len | input | LEN_W | Guard length in cycles |
| cfg_slots | input | log2(MAX_SLOTS+1) | Slots per round |
| cfg_num_sw | input | log2(MAX_SW+1) | Number of switches |
| cfg_hosts_per_sw | input | log2(MAX_HPS+1) | Hosts under each switch |
| sched_slot | output | log2(MAX_SLOTS) | Schedule read address: slot |
| sched_host | output | log2(MAX_SW)+log2(MAX_HPS) | Schedule read address: host |
| sched_entry | input | CLS_W+1 | Schedule read data; top bit set means idle |
| req_valid | output | 1 | Control request valid |
| req_ready | input | 1 | Control request accepted |
| req_host | output | log2(MAX_SW)+log2(MAX_HPS) | Target host index |
| req_cmd | output | 1 | 0 = stop all classes, 1 = resume one class |
| req_class | output | CLS_W | Class to resume (0 on stop commands) |
| busy | output | 1 | Round in progress |
| round_done | output | 1 | One-cycle pulse after the last slot |
| overrun | output | 1 | One-cycle pulse when a slot ends mid-step |

## Verification
The checker watches four properties on every cycle:

- the request handshake stays stable under backpressure, except when a slot end forces an abort;
- requests appear only inside a round;
- no resume is issued for an idle schedule entry;
- `round_done` is a single pulse that coincides with `busy` falling.

The remaining behaviours depend on a schedule and a configuration, so only the directed scenarios can show them:

- the rotating visit order;
- the exact slot-start and guard spacing in cycles;
- which hosts are skipped;
- the overrun count when a slot is too short for its host set.

// File: rtl/tdma_seq_pkg.sv
// Shared types for the TDMA slot sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package tdma_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PAUSE,
        ST_GUARD,
        ST_UNPAUSE,
        ST_HOLD
    } seq_state_t;

    localparam logic CMD_STOP   = 1'b0;
    localparam logic CMD_RESUME = 1'b1;

endpackage

// File: rtl/tdma_slot_clock.sv
// Slot clock: counts cycles inside a slot and the slot index inside a round.
// Assumes: cfg_len >= 2 and cfg_slots >= 1, both stable while run is high.
module tdma_slot_clock #(
    parameter int LEN_W   = 16,
    parameter int SLOT_W  = 4,
    parameter int SLOTC_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               run,
    input  logic [LEN_W-1:0]   cfg_len,
    input  logic [SLOTC_W-1:0] cfg_slots,
    output logic [SLOT_W-1:0]  slot_idx,
    output logic               slot_end,
    output logic               last_slot
);

    logic [LEN_W-1:0] tick;

    assign slot_end  = run && (tick == cfg_len - LEN_W'(1));
    assign last_slot = (SLOTC_W'(slot_idx) == cfg_slots - SLOTC_W'(1));

    // Advance the in-slot tick and step the slot index at each slot end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick     <= '0;
            slot_idx <= '0;
        end else if (clear) begin
            tick     <= '0;
            slot_idx <= '0;
        end else if (run) begin
            if (slot_end) begin
                tick <= '0;
                if (!last_slot) slot_idx <= slot_idx + SLOT_W'(1);
            end else begin
                tick <= tick + LEN_W'(1);
            end
        end
    end

endmodule

// File: rtl/tdma_host_walker.sv
// Host walker: steps through hosts switch by switch, in a rotating order.
// The switch base and host base each move up by one on every slot rotation.
// Assumes: 1 <= cfg_num_sw <= MAX_SW and 1 <= cfg_hps <= MAX_HPS, stable in a round.
module tdma_host_walker #(
    parameter int MAX_SW  = 4,
    parameter int MAX_HPS = 4,
    parameter int SW_W    = (MAX_SW  > 1) ? $clog2(MAX_SW)  : 1,
    parameter int HPS_W   = (MAX_HPS > 1) ? $clog2(MAX_HPS) : 1,
    parameter int SWC_W   = $clog2(MAX_SW + 1),
    parameter int HPSC_W  = $clog2(MAX_HPS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              rotate,
    input  logic              reload,
    input  logic              advance,
    input  logic [SWC_W-1:0]  cfg_num_sw,
    input  logic [HPSC_W-1:0] cfg_hps,
    output logic [SW_W-1:0]   cur_sw,
    output logic [HPS_W-1:0]  cur_h,
    output logic              last
);

    logic [SW_W-1:0]  base_sw, n_sw, sw_inc, base_sw_inc;
    logic [HPS_W-1:0] base_h, n_h, h_inc, base_h_inc;
    logic             sw_done;

    // Wrapping increments of the current position and of the bases.
    always_comb begin
        sw_inc      = (SWC_W'(cur_sw)  + SWC_W'(1)  == cfg_num_sw) ? '0 : cur_sw  + SW_W'(1);
        h_inc       = (HPSC_W'(cur_h)  + HPSC_W'(1) == cfg_hps)    ? '0 : cur_h   + HPS_W'(1);
        base_sw_inc = (SWC_W'(base_sw) + SWC_W'(1)  == cfg_num_sw) ? '0 : base_sw + SW_W'(1);
        base_h_inc  = (HPSC_W'(base_h) + HPSC_W'(1) == cfg_hps)    ? '0 : base_h  + HPS_W'(1);
        sw_done     = (HPSC_W'(n_h) == cfg_hps - HPSC_W'(1));
        last        = sw_done && (SWC_W'(n_sw) == cfg_num_sw - SWC_W'(1));
    end

    // Hold the bases, the current position and the visit counters.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            base_sw <= '0;
            base_h  <= '0;
            cur_sw  <= '0;
            cur_h   <= '0;
            n_sw    <= '0;
            n_h     <= '0;
        end else if (rotate) begin
            base_sw <= base_sw_inc;
            base_h  <= base_h_inc;
            cur_sw  <= base_sw_inc;
            cur_h   <= base_h_inc;
            n_sw    <= '0;
            n_h     <= '0;
        end else if (reload) begin
            cur_sw <= base_sw;
            cur_h  <= base_h;
            n_sw   <= '0;
            n_h    <= '0;
        end else if (advance) begin
            if (sw_done) begin
                n_h    <= '0;
                cur_h  <= base_h;
                n_sw   <= n_sw + SW_W'(1);
                cur_sw <= sw_inc;
            end else begin
                n_h   <= n_h + HPS_W'(1);
                cur_h <= h_inc;
            end
        end
    end

endmodule

// File: rtl/tdma_seq_ctrl.sv
// Step controller: runs the stop step, the guard wait and the resume step of every slot.
// It also raises the overrun and round-done pulses.
// Assumes: cfg_guard_len >= 1; slot_end is only high while busy.
module tdma_seq_ctrl
    import tdma_seq_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             slot_end,
    input  logic             last_slot,
    input  logic             walk_last,
    input  logic             req_ready,
    input  logic             entry_idle,
    input  logic [LEN_W-1:0] cfg_guard_len,
    output logic             busy,
    output logic             timer_clear,
    output logic             walk_clear,
    output logic             walk_rotate,
    output logic             walk_reload,
    output logic             walk_advance,
    output logic             req_valid,
    output logic             req_cmd,
    output logic             round_done,
    output logic             overrun
);

    seq_state_t       state;
    logic [LEN_W-1:0] gcnt;
    logic             step_done, leave_pause;

    // Decode the handshake and the walker controls from the current step.
    always_comb begin
        busy         = (state != ST_IDLE);
        timer_clear  = (state == ST_IDLE) && start;
        walk_clear   = timer_clear;
        walk_rotate  = slot_end && !last_slot;
        req_valid    = (state == ST_PAUSE) || ((state == ST_UNPAUSE) && !entry_idle);
        req_cmd      = (state == ST_UNPAUSE) ? CMD_RESUME : CMD_STOP;
        step_done    = ((state == ST_PAUSE) && req_ready) ||
                       ((state == ST_UNPAUSE) && (entry_idle || req_ready));
        leave_pause  = (state == ST_PAUSE) && req_ready && walk_last && !slot_end;
        walk_reload  = leave_pause;
        walk_advance = step_done && !walk_last && !slot_end;
    end

    // Step sequencing; a slot end overrides every step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            gcnt       <= '0;
            round_done <= 1'b0;
            overrun    <= 1'b0;
        end else begin
            round_done <= 1'b0;
            overrun    <= 1'b0;
            if (slot_end) begin
                overrun <= (state != ST_HOLD);
                if (last_slot) begin
                    state      <= ST_IDLE;
                    round_done <= 1'b1;
                end else begin
                    state <= ST_PAUSE;
                end
            end else begin
                case (state)
                    ST_IDLE:    if (start) state <= ST_PAUSE;
                    ST_PAUSE:   if (leave_pause) begin
                                    state <= ST_GUARD;
                                    gcnt  <= '0;
                                end
                    ST_GUARD:   if (gcnt == cfg_guard_len - LEN_W'(1)) state <= ST_UNPAUSE;
                                else gcnt <= gcnt + LEN_W'(1);
                    ST_UNPAUSE: if (step_done && walk_last) state <= ST_HOLD;
                    default:    ;
                endcase
            end
        end
    end

endmodule

// File: rtl/tdma_slot_sequencer.sv
// TDMA slot sequencer top. It joins the slot clock, the host walker and the step controller.
// It presents the schedule read address and drives the control-request handshake.
// Assumes: the schedule store answers in the same cycle; configuration is stable while busy.
module tdma_slot_sequencer #(
    parameter int MAX_SW    = 4,
    parameter int MAX_HPS   = 4,
    parameter int MAX_SLOTS = 16,
    parameter int CLS_W     = 3,
    parameter int LEN_W     = 16,
    localparam int SW_W     = (MAX_SW    > 1) ? $clog2(MAX_SW)    : 1,
    localparam int HPS_W    = (MAX_HPS   > 1) ? $clog2(MAX_HPS)   : 1,
    localparam int SLOT_W   = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
    localparam int SWC_W    = $clog2(MAX_SW + 1),
    localparam int HPSC_W   = $clog2(MAX_HPS + 1),
    localparam int SLOTC_W  = $clog2(MAX_SLOTS + 1),
    localparam int HOST_W   = SW_W + HPS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [LEN_W-1:0]   cfg_slot_len,
    input  logic [LEN_W-1:0]   cfg_guard_len,
    input  logic [SLOTC_W-1:0] cfg_slots,
    input  logic [SWC_W-1:0]   cfg_num_sw,
    input  logic [HPSC_W-1:0]  cfg_hosts_per_sw,
    output logic [SLOT_W-1:0]  sched_slot,
    output logic [HOST_W-1:0]  sched_host,
    input  logic [CLS_W:0]     sched_entry,
    output logic               req_valid,
    input  logic               req_ready,
    output logic [HOST_W-1:0]  req_host,
    output logic               req_cmd,
    output logic [CLS_W-1:0]   req_class,
    output logic               busy,
    output logic               round_done,
    output logic               overrun
);

    logic              slot_end, last_slot, timer_clear;
    logic              walk_clear, walk_rotate, walk_reload, walk_advance, walk_last;
    logic [SW_W-1:0]   cur_sw;
    logic [HPS_W-1:0]  cur_h;

    tdma_slot_clock #(.LEN_W(LEN_W), .SLOT_W(SLOT_W), .SLOTC_W(SLOTC_W)) u_clock (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (timer_clear),
        .run       (busy),
        .cfg_len   (cfg_slot_len),
        .cfg_slots (cfg_slots),
        .slot_idx  (sched_slot),
        .slot_end  (slot_end),
        .last_slot (last_slot)
    );

    tdma_host_walker #(
        .MAX_SW(MAX_SW), .MAX_HPS(MAX_HPS), .SW_W(SW_W), .HPS_W(HPS_W),
        .SWC_W(SWC_W), .HPSC_W(HPSC_W)
    ) u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (walk_clear),
        .rotate     (walk_rotate),
        .reload     (walk_reload),
        .advance    (walk_advance),
        .cfg_num_sw (cfg_num_sw),
        .cfg_hps    (cfg_hosts_per_sw),
        .cur_sw     (cur_sw),
        .cur_h      (cur_h),
        .last       (walk_last)
    );

    tdma_seq_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .slot_end      (slot_end),
        .last_slot     (last_slot),
        .walk_last     (walk_last),
        .req_ready     (req_ready),
        .entry_idle    (sched_entry[CLS_W]),
        .cfg_guard_len (cfg_guard_len),
        .busy          (busy),
        .timer_clear   (timer_clear),
        .walk_clear    (walk_clear),
        .walk_rotate   (walk_rotate),
        .walk_reload   (walk_reload),
        .walk_advance  (walk_advance),
        .req_valid     (req_valid),
        .req_cmd       (req_cmd),
        .round_done    (round_done),
        .overrun       (overrun)
    );

    // Host index is {switch, host-in-switch}; the class is shown only on resume commands.
    assign sched_host = {cur_sw, cur_h};
    assign req_host   = sched_host;
    assign req_class  = req_cmd ? sched_entry[CLS_W-1:0] : '0;

endmodule

// File: rtl/tdma_slot_sequencer_chk.sv
// Property checker for the TDMA slot sequencer, bound to every instance of the top.
// Assumes: the same synchronous active-low reset as the design.
module tdma_slot_sequencer_chk #(
    parameter int CLS_W  = 3,
    parameter int HOST_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              req_valid,
    input logic              req_ready,
    input logic [HOST_W-1:0] req_host,
    input logic              req_cmd,
    input logic [CLS_W:0]    sched_entry,
    input logic              round_done,
    input logic              overrun
);

    // R8: a stalled request holds its host and command unless a slot end aborts it
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=>
            (overrun || (req_valid && $stable(req_host) && $stable(req_cmd))));

    // R10: no requests outside a round
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !req_valid);

    // R10: the round-done pulse coincides with busy falling
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        round_done |-> (!busy && $past(busy)));

    // R10: round-done lasts one cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        round_done |=> !round_done);

    // R5: a resume command never goes out for an idle entry
    a_r5_no_idle_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cmd) |-> !sched_entry[CLS_W]);

    // R9: overrun only follows a cycle inside a round
    a_r9_overrun_in_round: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(busy));

endmodule

bind tdma_slot_sequencer tdma_slot_sequencer_chk #(.CLS_W(CLS_W), .HOST_W(HOST_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_host    (req_host),
    .req_cmd     (req_cmd),
    .sched_entry (sched_entry),
    .round_done  (round_done),
    .overrun     (overrun)
);

// File: tb/tb_tdma_slot_sequencer.sv
// Directed bench for the TDMA slot sequencer: one task per scenario, each checking its own results.
module tb_tdma_slot_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] cfg_slot_len = 16'd40;
    logic [15:0] cfg_guard_len = 16'd5;
    logic [4:0]  cfg_slots = 5'd1;
    logic [2:0]  cfg_num_sw = 3'd1;
    logic [2:0]  cfg_hosts_per_sw = 3'd1;
    logic [3:0]  sched_slot;
    logic [3:0]  sched_host;
    logic [3:0]  sched_entry;
    logic        req_valid;
    logic        req_ready = 1'b1;
    logic [3:0]  req_host;
    logic        req_cmd;
    logic [2:0]  req_class;
    logic        busy, round_done, overrun;

    tdma_slot_sequencer dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_slot_len(cfg_slot_len), .cfg_guard_len(cfg_guard_len), .cfg_slots(cfg_slots),
        .cfg_num_sw(cfg_num_sw), .cfg_hosts_per_sw(cfg_hosts_per_sw),
        .sched_slot(sched_slot), .sched_host(sched_host), .sched_entry(sched_entry),
        .req_valid(req_valid), .req_ready(req_ready), .req_host(req_host),
        .req_cmd(req_cmd), .req_class(req_class),
        .busy(busy), .round_done(round_done), .overrun(overrun)
    );

    always #4 clk = ~clk;   // 125 MHz

    logic [3:0] smem [16][16];
    assign sched_entry = smem[sched_slot][sched_host];

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    int cyc      = 0;
    bit bp_mode  = 0;

    int rec_n = 0;
    int rec_host [512];
    int rec_cmd  [512];
    int rec_cls  [512];
    int rec_cyc  [512];
    int done_cyc = -1;
    int done_cnt = 0;
    int ovr_cnt  = 0;

    bit hold_pend = 0;
    int hold_host = 0;
    int hold_cmd  = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    // Cycle counter and ready pattern, both updated just after the edge.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        req_ready <= bp_mode ? ((cyc % 3) != 1) : 1'b1;
    end

    // Record accepted requests and pulses; check R8 handshake stability.
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_pend && !overrun) begin
                chk(req_valid && int'(req_host) == hold_host && int'(req_cmd) == hold_cmd,
                    "R8 stalled request changed", int'(req_host), hold_host);
            end
            hold_pend = req_valid && !req_ready;
            hold_host = int'(req_host);
            hold_cmd  = int'(req_cmd);
            if (req_valid && req_ready && rec_n < 512) begin
                rec_host[rec_n] = int'(req_host);
                rec_cmd[rec_n]  = int'(req_cmd);
                rec_cls[rec_n]  = int'(req_class);
                rec_cyc[rec_n]  = cyc;
                rec_n++;
            end
            if (round_done) begin done_cyc = cyc; done_cnt++; end
            if (overrun) ovr_cnt++;
        end
    end

    function automatic int exp_host(int k, int p, int nsw, int hps);
        int s = ((k % nsw) + p / hps) % nsw;
        int h = ((k % hps) + p % hps) % hps;
        return s * 4 + h;
    endfunction

    task automatic fill(input int idle_slot);
        for (int k = 0; k < 16; k++)
            for (int h = 0; h < 16; h++)
                smem[k][h] = (k == idle_slot || ((k * 5 + h * 3) % 7 == 0)) ? 4'h8 : 4'((k + h) % 8);
    endtask

    // Run one round and compare every accepted request with the model order.
    task automatic run_round(input int nsw, input int hps, input int slots, input int len,
                             input int guard, input bit bp, input bit expect_ovr);
        int c0, ptr, n, npause, base, last_p, wd;
        cfg_num_sw = 3'(nsw); cfg_hosts_per_sw = 3'(hps); cfg_slots = 5'(slots);
        cfg_slot_len = 16'(len); cfg_guard_len = 16'(guard);
        bp_mode = bp;
        repeat (2) @(negedge clk);
        rec_n = 0; done_cyc = -1; done_cnt = 0; ovr_cnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        c0 = cyc;
        wd = 0;
        while (done_cnt == 0 && wd < 5000) begin @(negedge clk); wd++; end
        @(negedge clk);
        chk(!busy && !req_valid, "R10 quiet after round", int'(busy), 0);
        chk(done_cnt == 1, "R10 one done pulse", done_cnt, 1);
        chk(done_cyc == c0 + slots * len, "R10 done timing", done_cyc, c0 + slots * len);
        chk(ovr_cnt == (expect_ovr ? slots : 0), "R9 overrun count", ovr_cnt, expect_ovr ? slots : 0);
        ptr = 0;
        n = nsw * hps;
        for (int k = 0; k < slots; k++) begin
            base = c0 + k * len;
            npause = expect_ovr ? len : n;
            for (int p = 0; p < npause; p++) begin
                chk(rec_cmd[ptr] == 0, "R2 stop command expected", rec_cmd[ptr], 0);
                chk(rec_host[ptr] == exp_host(k, p, nsw, hps), "R6 R7 stop host order",
                    rec_host[ptr], exp_host(k, p, nsw, hps));
                if (!bp) chk(rec_cyc[ptr] == base + p, "R3 slot start timing", rec_cyc[ptr], base + p);
                ptr++;
            end
            last_p = base + n - 1;
            if (!expect_ovr) begin
                for (int p = 0; p < n; p++) begin
                    int hh = exp_host(k, p, nsw, hps);
                    logic [3:0] e = smem[k][hh];
                    if (!e[3]) begin
                        chk(rec_cmd[ptr] == 1, "R5 resume command", rec_cmd[ptr], 1);
                        chk(rec_host[ptr] == hh, "R6 R7 resume host order", rec_host[ptr], hh);
                        chk(rec_cls[ptr] == int'(e[2:0]), "R5 resume class", rec_cls[ptr], int'(e[2:0]));
                        if (!bp) chk(rec_cyc[ptr] == last_p + guard + 1 + p, "R4 guard spacing",
                                     rec_cyc[ptr], last_p + guard + 1 + p);
                        ptr++;
                    end
                end
            end
        end
        chk(rec_n == ptr, "R5 no extra requests (idle hosts skipped)", rec_n, ptr);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!req_valid && !busy && !round_done && !overrun, "R1 state in reset", int'(busy), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!req_valid && !busy && !round_done && !overrun, "R1 state after reset", int'(req_valid), 0);
    endtask

    task automatic t_basic();      fill(99); run_round(2, 2, 3, 40, 5, 0, 0); endtask
    task automatic t_idle_slot();  fill(2);  run_round(3, 4, 4, 60, 3, 0, 0); endtask
    task automatic t_restart();    fill(99); run_round(2, 2, 3, 40, 5, 0, 0); endtask
    task automatic t_backpress();  fill(99); run_round(2, 3, 3, 100, 4, 1, 0); endtask
    task automatic t_overrun();    fill(99); run_round(4, 4, 2, 12, 2, 0, 1); endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        summary();
    end

    initial begin
        t_reset();
        t_basic();
        t_idle_slot();
        t_restart();
        t_backpress();
        t_overrun();
        repeat (3) @(negedge clk);
        summary();
    end

endmodule